// File: doc/BRIEF.md
# Serial Receiver with Address-Frame Filtering

This block is the receive half of an asynchronous serial port. It watches a serial input line and finds the falling edge of a start bit. A sampling enable running at sixteen times the bit rate confirms the start bit at its middle. The block then samples each data bit at its centre, least significant bit first. Once the stop bit has been sampled, the finished frame is handed to an 8-bit holding register that software can only read. Two status outputs go with that register: a data-ready flag and a single error flag that covers both framing errors and overruns. A level interrupt request is raised while either flag is set and the interrupt enable is high.

A 2-bit mode input selects the frame shape:
- 8 data bits.
- 7 data bits.
- 8 data bits plus a ninth address bit, which is used for filtering.
- 8 data bits plus a ninth bit that is ignored.

In the filtering mode, only frames whose ninth bit is 1 reach the holding register. This lets a node on a shared line wake up on address frames and skip data frames meant for other nodes. A framing error is still reported in this mode whatever the ninth bit holds.

Software clears both flags with a fixed two-step sequence: a status read strobe, then a data read strobe. A data read that was not preceded by a status read leaves the flags alone.

Top module: `uart_rx_mp`

## Requirements
- R1: The data-ready and error flags change only after the stop bit has been sampled at its centre. Sixteen clocks into the stop bit, a frame still leaves data-ready at 0.
- R2: In mode 0 (mode input 2'b00), a frame with a stop bit of 1 loads its 8 data bits into the holding register, first-received bit in bit 0, and sets data-ready to 1.
- R3: In mode 1 (2'b01), a frame carries 7 data bits. The holding register then reads bit 7 as 0, and the bit after the seventh data bit is taken as the stop bit.
- R4: The interrupt output is 1 exactly when the interrupt enable is 1 and data-ready or error is 1. With the enable at 0 it stays 0.
- R5: In mode 2 (2'b10), a frame whose ninth bit is 0 and whose stop bit is 1 leaves data-ready, error and the holding register unchanged.
- R6: In mode 2, a frame whose ninth bit is 1 loads its low 8 bits and sets data-ready.
- R7: A stop bit sampled as 0 sets the error flag. It does not load the holding register and does not set data-ready. This applies in mode 2 even when the ninth bit is 0.
- R8: When a frame that would be accepted completes while data-ready is still 1, the error flag is set and the holding register keeps its earlier contents.
- R9: A status read strobe followed by a data read strobe, with no data read between them, clears both flags.
- R10: A data read strobe with no status read pending leaves both flags unchanged. Each status read permits only one clearing data read.
- R11: In mode 3 (2'b11), a 9-bit frame is accepted whatever its ninth bit holds, and the low 8 bits are loaded.
- R12: After reset, data-ready, error and the interrupt output are 0. The holding register has no defined reset value.
- R13: A low pulse on the serial input that ends before the middle of a bit period does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial data line, idle high |
| tick16_i | input | 1 | One-clock enable at sixteen times the bit rate |
| mode_i | input | 2 | Frame mode: 0 = 8 bits, 1 = 7 bits, 2 = 9 bits with address filter, 3 = 9 bits unfiltered |
| rie_i | input | 1 | Receive interrupt enable |
| stat_rd_i | input | 1 | Status register read strobe |
| data_rd_i | input | 1 | Holding register read strobe |
| rx_data_o | output | 8 | Holding register contents |
| rdrf_o | output | 1 | Data-ready flag |
| err_o | output | 1 | Overrun or framing error flag |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The frames sent to the block use asymmetric bit patterns, so a reversed bit order or a shifted sample point shows up as a wrong value.

- The 7-bit frame is chosen so that a receiver wrongly taking 8 bits would read the stop bit into bit 7.
- The filtering mode is given frames with the ninth bit at 0 and at 1, with stop bits both good and bad. This separates the address filter from the framing check.
- The unfiltered 9-bit mode receives the same ninth-bit values and must accept both.
- Back-to-back unread frames test the overrun path.
- Lone data reads, paired reads and a short glitch on an idle line test the clearing sequence and start-bit rejection.

// File: rtl/uart_rx_mp_pkg.sv
package uart_rx_mp_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_STOP  = 2'd3
   } rx_state_e;

   localparam logic [1:0] MODE_8N   = 2'd0;
   localparam logic [1:0] MODE_7N   = 2'd1;
   localparam logic [1:0] MODE_ADDR = 2'd2;
   localparam logic [1:0] MODE_9N   = 2'd3;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_i,
   output logic rx_o,
   output logic fall_o
);
   logic prev_q;

   generate
      if (STAGES == 0) begin : g_bypass
         assign rx_o = rx_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], rx_i};
         end
         assign rx_o = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= rx_o;
   end

   assign fall_o = prev_q & ~rx_o;
endmodule

// File: rtl/uart_rx_shift.sv
module uart_rx_shift
   import uart_rx_mp_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              rx_i,
   input  logic              fall_i,
   input  logic [1:0]        mode_i,
   output logic              done_o,
   output logic              ferr_o,
   output logic [1:0]        mode_o,
   output logic [DATA_W:0]   frame_o
);
   localparam int CNT_W = $clog2(OVS);
   localparam int IDX_W = $clog2(DATA_W + 2);
   localparam logic [CNT_W-1:0] HALF = CNT_W'(OVS / 2 - 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(OVS - 1);

   rx_state_e        st_q;
   logic [CNT_W-1:0] cnt_q;
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] last_idx;

   always_comb begin
      unique case (mode_o)
         MODE_7N:           last_idx = IDX_W'(DATA_W - 2);
         MODE_ADDR, MODE_9N: last_idx = IDX_W'(DATA_W);
         default:           last_idx = IDX_W'(DATA_W - 1);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         done_o  <= 1'b0;
         ferr_o  <= 1'b0;
         mode_o  <= MODE_8N;
         frame_o <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (fall_i) begin
                  st_q    <= ST_START;
                  cnt_q   <= '0;
                  idx_q   <= '0;
                  frame_o <= '0;
                  mode_o  <= mode_i;
               end
            end
            ST_START: begin
               if (tick_i) begin
                  if (cnt_q == HALF) begin
                     cnt_q <= '0;
                     st_q  <= rx_i ? ST_IDLE : ST_DATA;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
            end
            ST_DATA: begin
               if (tick_i) begin
                  if (cnt_q == FULL) begin
                     cnt_q          <= '0;
                     frame_o[idx_q] <= rx_i;
                     if (idx_q == last_idx) st_q <= ST_STOP;
                     else                   idx_q <= idx_q + IDX_W'(1);
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
            end
            default: begin
               if (tick_i) begin
                  if (cnt_q == FULL) begin
                     cnt_q  <= '0;
                     done_o <= 1'b1;
                     ferr_o <= ~rx_i;
                     st_q   <= ST_IDLE;
                  end else begin
                     cnt_q <= cnt_q + CNT_W'(1);
                  end
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
   import uart_rx_mp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic              ferr_i,
   input  logic [1:0]        mode_i,
   input  logic [DATA_W:0]   frame_i,
   input  logic              rie_i,
   input  logic              stat_rd_i,
   input  logic              data_rd_i,
   output logic [DATA_W-1:0] data_o,
   output logic              rdrf_o,
   output logic              err_o,
   output logic              irq_o,
   output logic              armed_o
);
   logic accept;
   logic clr;
   logic load;

   assign accept = (mode_i != MODE_ADDR) | frame_i[DATA_W];
   assign clr    = data_rd_i & armed_o;
   assign load   = done_i & ~ferr_i & accept & ~rdrf_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_o <= 1'b0;
      end else begin
         if (data_rd_i) armed_o <= 1'b0;
         if (stat_rd_i) armed_o <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdrf_o <= 1'b0;
         err_o  <= 1'b0;
      end else begin
         if (clr) begin
            rdrf_o <= 1'b0;
            err_o  <= 1'b0;
         end
         if (done_i) begin
            if (ferr_i)                err_o  <= 1'b1;
            else if (accept && rdrf_o) err_o  <= 1'b1;
            else if (accept)           rdrf_o <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (load) data_o <= frame_i[DATA_W-1:0];
   end

   assign irq_o = rie_i & (rdrf_o | err_o);
endmodule

// File: rtl/uart_rx_mp.sv
module uart_rx_mp
   import uart_rx_mp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_i,
   input  logic              tick16_i,
   input  logic [1:0]        mode_i,
   input  logic              rie_i,
   input  logic              stat_rd_i,
   input  logic              data_rd_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rdrf_o,
   output logic              err_o,
   output logic              irq_o
);
   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (SYNC_STAGES == 1 || SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   logic            rx_s_w;
   logic            fall_w;
   logic            done_w;
   logic            ferr_w;
   logic [1:0]      mode_q_w;
   logic [DATA_W:0] frame_w;
   logic            armed_w;

   uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .rx_i   (rx_i),
      .rx_o   (rx_s_w),
      .fall_o (fall_w)
   );

   uart_rx_shift #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick16_i),
      .rx_i    (rx_s_w),
      .fall_i  (fall_w),
      .mode_i  (mode_i),
      .done_o  (done_w),
      .ferr_o  (ferr_w),
      .mode_o  (mode_q_w),
      .frame_o (frame_w)
   );

   uart_rx_flags #(.DATA_W(DATA_W)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .done_i    (done_w),
      .ferr_i    (ferr_w),
      .mode_i    (mode_q_w),
      .frame_i   (frame_w),
      .rie_i     (rie_i),
      .stat_rd_i (stat_rd_i),
      .data_rd_i (data_rd_i),
      .data_o    (rx_data_o),
      .rdrf_o    (rdrf_o),
      .err_o     (err_o),
      .irq_o     (irq_o),
      .armed_o   (armed_w)
   );
endmodule

// File: rtl/uart_rx_mp_chk.sv
module uart_rx_mp_chk
   import uart_rx_mp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              done,
   input logic              ferr,
   input logic              bit9,
   input logic [1:0]        mode_q,
   input logic              armed,
   input logic              rie_i,
   input logic              data_rd_i,
   input logic [DATA_W-1:0] rx_data_o,
   input logic              rdrf_o,
   input logic              err_o,
   input logic              irq_o
);
   a_r1_flag_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdrf_o) |-> $past(done));

   a_r2_data_held: assert property (@(posedge clk) disable iff (!rst_n)
      rdrf_o |=> $stable(rx_data_o));

   a_r4_irq_on: assert property (@(posedge clk) disable iff (!rst_n)
      (rie_i && (rdrf_o || err_o)) |-> irq_o);

   a_r4_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
      !rie_i |-> !irq_o);

   a_r5_addr_filter: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !ferr && !bit9 && mode_q == MODE_ADDR && !(data_rd_i && armed))
      |=> ($stable(rdrf_o) && $stable(err_o) && $stable(rx_data_o)));

   a_r7_framing: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ferr) |=> err_o);

   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd_i && armed && !done) |=> (!rdrf_o && !err_o));

   a_r10_lone_read: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd_i && !armed && !done) |=> ($stable(rdrf_o) && $stable(err_o)));
endmodule

bind uart_rx_mp uart_rx_mp_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .done      (done_w),
   .ferr      (ferr_w),
   .bit9      (frame_w[DATA_W]),
   .mode_q    (mode_q_w),
   .armed     (armed_w),
   .rie_i     (rie_i),
   .data_rd_i (data_rd_i),
   .rx_data_o (rx_data_o),
   .rdrf_o    (rdrf_o),
   .err_o     (err_o),
   .irq_o     (irq_o)
);

// File: tb/uart_rx_mp_bench.sv
module uart_rx_mp_bench;
   localparam int BIT_CLKS = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx = 1'b1;
   logic       tick = 1'b0;
   logic [1:0] mode = 2'd0;
   logic       rie = 1'b1;
   logic       stat_rd = 1'b0;
   logic       data_rd = 1'b0;
   logic [7:0] rx_data;
   logic       rdrf;
   logic       err;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   uart_rx_mp u_uart_rx_mp (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_i      (rx),
      .tick16_i  (tick),
      .mode_i    (mode),
      .rie_i     (rie),
      .stat_rd_i (stat_rd),
      .data_rd_i (data_rd),
      .rx_data_o (rx_data),
      .rdrf_o    (rdrf),
      .err_o     (err),
      .irq_o     (irq)
   );

   initial begin
      forever begin
         repeat (3) @(negedge clk);
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [8:0] bits, input int nbits, input logic stop, input bit mid_chk);
      rx = 1'b0;
      repeat (BIT_CLKS) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         rx = bits[i];
         repeat (BIT_CLKS) @(negedge clk);
      end
      rx = stop;
      repeat (16) @(negedge clk);
      if (mid_chk) chk("R1 flag early", int'(rdrf), 0);
      repeat (BIT_CLKS - 16) @(negedge clk);
      rx = 1'b1;
      repeat (BIT_CLKS) @(negedge clk);
   endtask

   task automatic rd_status();
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic rd_data();
      data_rd = 1'b1;
      @(negedge clk);
      data_rd = 1'b0;
      @(negedge clk);
   endtask

   task automatic clear_flags();
      rd_status();
      rd_data();
   endtask

   task automatic t_reset();
      chk("R12 rdrf", int'(rdrf), 0);
      chk("R12 err", int'(err), 0);
      chk("R12 irq", int'(irq), 0);
   endtask

   task automatic t_mode0();
      mode = 2'd0; rie = 1'b1;
      send(9'h0A5, 8, 1'b1, 1'b1);
      chk("R2 data", int'(rx_data), 8'hA5);
      chk("R2 rdrf", int'(rdrf), 1);
      chk("R4 irq on", int'(irq), 1);
      clear_flags();
      chk("R9 rdrf cleared", int'(rdrf), 0);
      chk("R4 irq off", int'(irq), 0);
   endtask

   task automatic t_lone_read();
      mode = 2'd0;
      send(9'h03C, 8, 1'b1, 1'b0);
      rd_data();
      chk("R10 lone read keeps rdrf", int'(rdrf), 1);
      clear_flags();
      chk("R9 paired read", int'(rdrf), 0);
      send(9'h0C3, 8, 1'b1, 1'b0);
      rd_data();
      chk("R10 status consumed", int'(rdrf), 1);
      chk("R2 second data", int'(rx_data), 8'hC3);
      clear_flags();
   endtask

   task automatic t_no_irq();
      rie = 1'b0;
      send(9'h05A, 8, 1'b1, 1'b0);
      chk("R4 rdrf set", int'(rdrf), 1);
      chk("R4 irq masked", int'(irq), 0);
      clear_flags();
      rie = 1'b1;
   endtask

   task automatic t_mode1();
      mode = 2'd1;
      send(9'h06A, 7, 1'b1, 1'b0);
      chk("R3 seven bits", int'(rx_data), 8'h6A);
      chk("R3 rdrf", int'(rdrf), 1);
      clear_flags();
   endtask

   task automatic t_mode2();
      mode = 2'd2;
      send(9'h011, 9, 1'b1, 1'b0);
      chk("R5 rdrf", int'(rdrf), 0);
      chk("R5 err", int'(err), 0);
      chk("R5 data kept", int'(rx_data), 8'h6A);
      send(9'h142, 9, 1'b1, 1'b0);
      chk("R6 data", int'(rx_data), 8'h42);
      chk("R6 rdrf", int'(rdrf), 1);
      clear_flags();
      send(9'h024, 9, 1'b0, 1'b0);
      chk("R7 err", int'(err), 1);
      chk("R7 rdrf", int'(rdrf), 0);
      chk("R7 data kept", int'(rx_data), 8'h42);
      chk("R4 irq on err", int'(irq), 1);
      clear_flags();
      chk("R9 err cleared", int'(err), 0);
   endtask

   task automatic t_overrun();
      mode = 2'd0;
      send(9'h081, 8, 1'b1, 1'b0);
      send(9'h018, 8, 1'b1, 1'b0);
      chk("R8 err", int'(err), 1);
      chk("R8 rdrf", int'(rdrf), 1);
      chk("R8 data kept", int'(rx_data), 8'h81);
      clear_flags();
   endtask

   task automatic t_mode3();
      mode = 2'd3;
      send(9'h099, 9, 1'b1, 1'b0);
      chk("R11 bit9 zero", int'(rx_data), 8'h99);
      chk("R11 rdrf", int'(rdrf), 1);
      clear_flags();
      send(9'h166, 9, 1'b1, 1'b0);
      chk("R11 bit9 one", int'(rx_data), 8'h66);
      clear_flags();
   endtask

   task automatic t_glitch();
      mode = 2'd0;
      rx = 1'b0;
      repeat (12) @(negedge clk);
      rx = 1'b1;
      repeat (20 * BIT_CLKS) @(negedge clk);
      chk("R13 rdrf", int'(rdrf), 0);
      chk("R13 err", int'(err), 0);
      send(9'h0E7, 8, 1'b1, 1'b0);
      chk("R13 next frame", int'(rx_data), 8'hE7);
      clear_flags();
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_mode0();
      t_lone_read();
      t_no_irq();
      t_mode1();
      t_mode2();
      t_overrun();
      t_mode3();
      t_glitch();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule